// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drives outgoing frames from a ring of descriptors that software builds in a memory it shares with the engine. Each descriptor takes two 32-bit words. The first word holds a 16-bit status in its upper half and a 16-bit byte length in its lower half. The second word holds the buffer pointer. Software fills descriptors, sets their ready flag and writes a clear-halt command. The engine then reads the descriptors in order and hands each buffer pointer, length and framing flags to a frame-send port. When the sender reports completion, the engine writes the status word back with the ready flag cleared and moves to the next entry.

The ring has no fixed size. An entry carrying the wrap flag sends the engine back to the base address, and the index also rolls over at 2^IDX_W entries. When the engine meets an entry that is not ready, it halts itself and stays halted until the next clear-halt command. A stop request lets the frame in flight complete and then parks the engine, which raises a completion event. Event bits are write-one-to-clear and are masked into a single interrupt line.

The state machine has eight states:
- HALT is the reset state. It waits for clear-halt.
- RDHDR issues the read of word 0.
- CAPHDR tests the ready flag.
- RDPTR issues the read of word 1.
- CAPPTR latches the pointer.
- SEND holds the request until the sender reports done.
- WBACK writes the status back and advances the index.
- STOP holds while the stop request is set.

The transitions are:
- HALT to STOP on a stop request, otherwise HALT to RDHDR on clear-halt.
- RDHDR to STOP on a stop request, otherwise RDHDR to CAPHDR.
- CAPHDR to HALT when the entry is not ready, otherwise CAPHDR to RDPTR.
- RDPTR to CAPPTR, then CAPPTR to SEND.
- SEND to WBACK on done.
- WBACK to STOP on a stop request, otherwise WBACK to RDHDR.
- STOP to HALT when the stop request is cleared.

Top module: `txring_engine`

## Requirements
- R1: After reset the engine is halted. The status register (address 2) reads bit0=1 (halted), bit1=0 (stopped) and index field [31:16]=0. The event register (address 3) reads 0, irq is 0 and snd_req is 0.
- R2: After a clear-halt command (write address 2 with bit0=1), the engine reads descriptor word 0 at base+8*index and word 1 at base+8*index+4. Read data arrives one cycle after mem_rd.
- R3: For a descriptor whose status bit15 (ready) is set, snd_req rises carrying the word-1 pointer and the length. snd_last is status bit11 and snd_crc is status bit10. The request and its payload stay steady until snd_done.
- R4: One cycle after snd_done, word 0 is rewritten. The length and the other status bits are kept, bit15 is cleared, and bit1 is set if snd_underrun accompanied snd_done.
- R5: After a write-back the index advances by one, or returns to 0 when the entry had status bit13 (wrap) set.
- R6: An entry with bit15 clear produces no request. It halts the engine at that same index and sets event bit2. The engine stays halted until clear-halt, then resumes at that index.
- R7: Setting control bit0 (address 1) lets the current frame finish, then parks the engine. The status register then shows bit1=1, the index points past the finished entry, and event bit1 is set. Clearing the bit returns the engine to halted.
- R8: A completed entry with status bit12 (interrupt) sets event bit0. Writing 1 to an event bit clears it, and irq is high exactly when an event bit is set whose bit in the mask register (address 4) is also set.
- R9: Writing the base register (address 0, low three bits forced to 0) resets the index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_rd | output | 1 | Descriptor memory read request |
| mem_wr | output | 1 | Descriptor memory write request |
| mem_addr | output | 32 | Descriptor memory byte address |
| mem_wdata | output | 32 | Descriptor write-back word |
| mem_rdata | input | 32 | Descriptor read word, valid one cycle after mem_rd |
| snd_req | output | 1 | Frame-send request, held until snd_done |
| snd_ptr | output | 32 | Buffer pointer of the frame |
| snd_len | output | 16 | Frame byte length |
| snd_last | output | 1 | Buffer ends the frame |
| snd_crc | output | 1 | Sender appends the check sequence |
| snd_done | input | 1 | One-cycle completion pulse |
| snd_underrun | input | 1 | Completion came with an underrun |
| irq | output | 1 | Masked event interrupt |

## Verification
The assertions assume that the sender pulses snd_done for a single cycle, and only while snd_req is high. They also assume that the memory returns read data on the cycle after mem_rd. The bench's sender and memory models are built to keep these rules: the sender answers a fixed number of cycles after the request and then waits for the request to fall, and the memory registers its read word on the mem_rd edge. Register writes last exactly one cycle. The base register is only rewritten while the engine is halted, so an index reset never lands in the middle of a frame.

// File: rtl/txring_pkg.sv
package txring_pkg;

    typedef enum logic [2:0] {
        S_HALT,
        S_RDHDR,
        S_CAPHDR,
        S_RDPTR,
        S_CAPPTR,
        S_SEND,
        S_WBACK,
        S_STOP
    } txr_state_e;

    // status word bit positions (software and engine agree on these)
    localparam int F_READY = 15;
    localparam int F_WRAP  = 13;
    localparam int F_INTR  = 12;
    localparam int F_LAST  = 11;
    localparam int F_CRC   = 10;
    localparam int F_UNDR  = 1;

    // register addresses
    localparam logic [2:0] RA_BASE = 3'd0;
    localparam logic [2:0] RA_CTRL = 3'd1;
    localparam logic [2:0] RA_CMD  = 3'd2;
    localparam logic [2:0] RA_EVT  = 3'd3;
    localparam logic [2:0] RA_MASK = 3'd4;

    // event bits
    localparam int EV_FRAME = 0;
    localparam int EV_STOP  = 1;
    localparam int EV_HALT  = 2;
    localparam int EV_W     = 3;

endpackage

// File: rtl/txr_regs.sv
module txr_regs
    import txring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [AW-1:0]    reg_wdata,
    output logic [AW-1:0]    reg_rdata,
    input  logic [EV_W-1:0]  ev_set,
    input  logic             halted,
    input  logic             stopped,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    base_addr,
    output logic             stop_req,
    output logic             clr_halt,
    output logic             base_wr,
    output logic [EV_W-1:0]  ev_q,
    output logic             irq
);

    localparam int ALIGN = 3;

    logic [AW-1:0]   base_q;
    logic            stop_q;
    logic [EV_W-1:0] mask_q;
    logic [EV_W-1:0] ev_r;
    logic [EV_W-1:0] w1c;

    assign base_wr  = reg_we && (reg_addr == RA_BASE);
    assign clr_halt = reg_we && (reg_addr == RA_CMD) && reg_wdata[0];
    assign w1c      = (reg_we && (reg_addr == RA_EVT)) ? reg_wdata[EV_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            stop_q <= 1'b0;
            mask_q <= '0;
            ev_r   <= '0;
        end else begin
            if (base_wr)
                base_q <= {reg_wdata[AW-1:ALIGN], {ALIGN{1'b0}}};
            if (reg_we && (reg_addr == RA_CTRL))
                stop_q <= reg_wdata[0];
            if (reg_we && (reg_addr == RA_MASK))
                mask_q <= reg_wdata[EV_W-1:0];
            ev_r <= (ev_r & ~w1c) | ev_set;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_BASE: reg_rdata = base_q;
            RA_CTRL: reg_rdata[0] = stop_q;
            RA_CMD: begin
                reg_rdata[0]           = halted;
                reg_rdata[1]           = stopped;
                reg_rdata[16 +: IDX_W] = idx;
            end
            RA_EVT:  reg_rdata[EV_W-1:0] = ev_r;
            RA_MASK: reg_rdata[EV_W-1:0] = mask_q;
            default: reg_rdata = '0;
        endcase
    end

    assign base_addr = base_q;
    assign stop_req  = stop_q;
    assign ev_q      = ev_r;
    assign irq       = |(ev_r & mask_q);

endmodule

// File: rtl/txr_fsm.sv
module txr_fsm
    import txring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 8,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    base_addr,
    input  logic             clr_halt,
    input  logic             base_wr,
    input  logic             stop_req,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [AW-1:0]    mem_wdata,
    input  logic [AW-1:0]    mem_rdata,
    output logic             snd_req,
    output logic [AW-1:0]    snd_ptr,
    output logic [LEN_W-1:0] snd_len,
    output logic             snd_last,
    output logic             snd_crc,
    input  logic             snd_done,
    input  logic             snd_underrun,
    output logic [EV_W-1:0]  ev_set,
    output logic             halted,
    output logic             stopped,
    output logic [IDX_W-1:0] idx
);

    localparam int ST_W      = AW - LEN_W;
    localparam int DESC_SH   = 3;
    localparam int PTR_OFS   = 4;

    txr_state_e state, nxt;

    logic [ST_W-1:0]  st_q;
    logic [LEN_W-1:0] len_q;
    logic [AW-1:0]    ptr_q;
    logic             und_q;
    logic [IDX_W-1:0] idx_q;
    logic [AW-1:0]    desc_addr;
    logic [ST_W-1:0]  st_wb;
    logic             hdr_ready;

    assign desc_addr = base_addr + AW'({idx_q, {DESC_SH{1'b0}}});
    assign hdr_ready = mem_rdata[LEN_W + F_READY];

    always_comb begin
        st_wb          = st_q;
        st_wb[F_READY] = 1'b0;
        st_wb[F_UNDR]  = st_q[F_UNDR] | und_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_HALT;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_HALT:   if (stop_req) nxt = S_STOP;
                      else if (clr_halt) nxt = S_RDHDR;
            S_RDHDR:  nxt = stop_req ? S_STOP : S_CAPHDR;
            S_CAPHDR: nxt = hdr_ready ? S_RDPTR : S_HALT;
            S_RDPTR:  nxt = S_CAPPTR;
            S_CAPPTR: nxt = S_SEND;
            S_SEND:   if (snd_done) nxt = S_WBACK;
            S_WBACK:  nxt = stop_req ? S_STOP : S_RDHDR;
            S_STOP:   if (!stop_req) nxt = S_HALT;
            default:  nxt = S_HALT;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = {st_wb, len_q};
        snd_req   = 1'b0;
        ev_set    = '0;
        unique case (state)
            S_HALT:   ev_set[EV_STOP] = stop_req;
            S_RDHDR:  begin
                mem_rd          = !stop_req;
                ev_set[EV_STOP] = stop_req;
            end
            S_CAPHDR: ev_set[EV_HALT] = !hdr_ready;
            S_RDPTR:  begin
                mem_rd   = 1'b1;
                mem_addr = desc_addr + AW'(PTR_OFS);
            end
            S_CAPPTR: ;
            S_SEND:   snd_req = 1'b1;
            S_WBACK:  begin
                mem_wr           = 1'b1;
                ev_set[EV_FRAME] = st_q[F_INTR];
                ev_set[EV_STOP]  = stop_req;
            end
            S_STOP:   ;
            default:  ;
        endcase
    end

    // descriptor datapath and ring index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            len_q <= '0;
            ptr_q <= '0;
            und_q <= 1'b0;
            idx_q <= '0;
        end else begin
            if (state == S_CAPHDR && hdr_ready) begin
                st_q  <= mem_rdata[AW-1:LEN_W];
                len_q <= mem_rdata[LEN_W-1:0];
                und_q <= 1'b0;
            end
            if (state == S_CAPPTR)
                ptr_q <= mem_rdata;
            if (state == S_SEND && snd_done)
                und_q <= snd_underrun;
            if (base_wr)
                idx_q <= '0;
            else if (state == S_WBACK)
                idx_q <= st_q[F_WRAP] ? '0 : idx_q + 1'b1;
        end
    end

    assign snd_ptr  = ptr_q;
    assign snd_len  = len_q;
    assign snd_last = st_q[F_LAST];
    assign snd_crc  = st_q[F_CRC];
    assign halted   = (state == S_HALT);
    assign stopped  = (state == S_STOP);
    assign idx      = idx_q;

endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 8,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [AW-1:0]    reg_wdata,
    output logic [AW-1:0]    reg_rdata,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [AW-1:0]    mem_wdata,
    input  logic [AW-1:0]    mem_rdata,
    output logic             snd_req,
    output logic [AW-1:0]    snd_ptr,
    output logic [LEN_W-1:0] snd_len,
    output logic             snd_last,
    output logic             snd_crc,
    input  logic             snd_done,
    input  logic             snd_underrun,
    output logic             irq
);

    logic [AW-1:0]    base_addr;
    logic             stop_req;
    logic             clr_halt;
    logic             base_wr;
    logic [EV_W-1:0]  ev_set;
    logic [EV_W-1:0]  ev_q;
    logic             eng_halted;
    logic             eng_stopped;
    logic [IDX_W-1:0] eng_idx;

    txr_regs #(.AW(AW), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_set    (ev_set),
        .halted    (eng_halted),
        .stopped   (eng_stopped),
        .idx       (eng_idx),
        .base_addr (base_addr),
        .stop_req  (stop_req),
        .clr_halt  (clr_halt),
        .base_wr   (base_wr),
        .ev_q      (ev_q),
        .irq       (irq)
    );

    txr_fsm #(.AW(AW), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_addr    (base_addr),
        .clr_halt     (clr_halt),
        .base_wr      (base_wr),
        .stop_req     (stop_req),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .snd_req      (snd_req),
        .snd_ptr      (snd_ptr),
        .snd_len      (snd_len),
        .snd_last     (snd_last),
        .snd_crc      (snd_crc),
        .snd_done     (snd_done),
        .snd_underrun (snd_underrun),
        .ev_set       (ev_set),
        .halted       (eng_halted),
        .stopped      (eng_stopped),
        .idx          (eng_idx)
    );

endmodule

// File: rtl/txring_engine_chk.sv
module txring_engine_chk
    import txring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic [AW-1:0]    mem_wdata,
    input logic             snd_req,
    input logic [AW-1:0]    snd_ptr,
    input logic [LEN_W-1:0] snd_len,
    input logic             snd_done,
    input logic             irq,
    input logic [EV_W-1:0]  ev_q,
    input logic             eng_halted,
    input logic             eng_stopped
);

    // R1 / R6: a halted or parked engine touches neither memory nor sender
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_halted || eng_stopped) |-> (!mem_rd && !mem_wr && !snd_req));

    // R2: never a read and a write in the same cycle
    assert_mem_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3: request and payload steady until done
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_req && !snd_done) |=> (snd_req && $stable(snd_ptr) && $stable(snd_len)));

    // R4: write-back follows done and never leaves ready set
    assert_wb_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_req && snd_done) |=> (mem_wr && !snd_req));

    assert_wb_clears_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !mem_wdata[LEN_W + F_READY]);

    // R8: the interrupt line needs a pending event
    assert_irq_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ev_q != '0));

endmodule

bind txring_engine txring_engine_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_wdata   (mem_wdata),
    .snd_req     (snd_req),
    .snd_ptr     (snd_ptr),
    .snd_len     (snd_len),
    .snd_done    (snd_done),
    .irq         (irq),
    .ev_q        (ev_q),
    .eng_halted  (eng_halted),
    .eng_stopped (eng_stopped)
);

// File: tb/txring_engine_test.sv
module txring_engine_test;

    localparam int NV = 6;
    // {status, length}: bit15 ready, 13 wrap, 12 intr, 11 last, 10 crc
    localparam logic [31:0] VEC [NV] = '{
        32'h8C00_0040,
        32'h9800_0041,
        32'h8400_05EE,
        32'h8800_003D,
        32'h9C00_0100,
        32'hA800_0020
    };
    localparam logic [31:0] TBASE = 32'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        snd_req;
    logic [31:0] snd_ptr;
    logic [15:0] snd_len;
    logic        snd_last, snd_crc;
    logic        snd_done = 1'b0;
    logic        snd_underrun = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [31:0] mem [64];
    logic [31:0] lg_ptr [32];
    logic [15:0] lg_len [32];
    logic        lg_last [32];
    logic        lg_crc [32];
    int          n_snd = 0;
    int          scnt = 0;

    always #10 clk = ~clk;

    txring_engine uut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .snd_req(snd_req), .snd_ptr(snd_ptr), .snd_len(snd_len), .snd_last(snd_last),
        .snd_crc(snd_crc), .snd_done(snd_done), .snd_underrun(snd_underrun), .irq(irq)
    );

    // shared memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];
        if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
    end

    // sender model: done four cycles after request, underrun on odd length
    always @(posedge clk) begin
        snd_done <= 1'b0;
        if (snd_req && !snd_done) begin
            if (scnt == 0) begin
                lg_ptr[n_snd]  <= snd_ptr;
                lg_len[n_snd]  <= snd_len;
                lg_last[n_snd] <= snd_last;
                lg_crc[n_snd]  <= snd_crc;
                n_snd <= n_snd + 1;
            end
            if (scnt == 3) begin
                snd_done     <= 1'b1;
                snd_underrun <= snd_len[0];
                scnt <= 0;
            end else begin
                scnt <= scnt + 1;
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            summary();
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // wait until status register shows any bit of m
    task automatic wait_st(logic [31:0] m);
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            rd_reg(3'd2, s);
            if ((s & m) != 0) return;
        end
        n_chk++; n_bad++;
        $display("FAIL wait: act=timeout exp=status %h", m);
    endtask

    function automatic logic [31:0] wb_exp(logic [31:0] w);
        logic [31:0] r = w;
        r[31] = 1'b0;
        if (w[0]) r[17] = 1'b1;
        return r;
    endfunction

    initial begin
        logic [31:0] rv;
        int base_n;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(3'd2, rv); chk("R1 status", rv, 32'h1);
        rd_reg(3'd3, rv); chk("R1 events", rv, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 snd_req", {31'b0, snd_req}, 32'h0);

        // table walk: R2 R3 R4 R5
        wr_reg(3'd0, TBASE);
        for (int i = 0; i < NV; i++) begin
            mem[(TBASE >> 2) + 2*i]     = VEC[i];
            mem[(TBASE >> 2) + 2*i + 1] = 32'h1000 + 32'(i) * 32'h100;
        end
        base_n = n_snd;
        wr_reg(3'd2, 32'h1);
        repeat (2) @(negedge clk);
        wait_st(32'h1);
        chk("R2 R3 send count", 32'(n_snd - base_n), NV);
        for (int i = 0; i < NV; i++) begin
            chk("R2 R3 ptr", lg_ptr[base_n+i], 32'h1000 + 32'(i) * 32'h100);
            chk("R3 len", {16'b0, lg_len[base_n+i]}, {16'b0, VEC[i][15:0]});
            chk("R3 last crc", {30'b0, lg_last[base_n+i], lg_crc[base_n+i]},
                {30'b0, VEC[i][27], VEC[i][26]});
            chk("R4 writeback", mem[(TBASE >> 2) + 2*i], wb_exp(VEC[i]));
        end
        rd_reg(3'd2, rv); chk("R5 R6 wrap halt idx0", rv, 32'h1);
        rd_reg(3'd3, rv); chk("R6 R8 events", rv, 32'h5);

        // R8 W1C and mask
        chk("R8 irq unmasked", {31'b0, irq}, 32'h0);
        wr_reg(3'd4, 32'h4);
        @(negedge clk); chk("R8 irq masked on", {31'b0, irq}, 32'h1);
        wr_reg(3'd3, 32'h1);
        rd_reg(3'd3, rv); chk("R8 w1c bit0", rv, 32'h4);
        wr_reg(3'd3, 32'h4);
        rd_reg(3'd3, rv); chk("R8 w1c bit2", rv, 32'h0);
        chk("R8 irq off", {31'b0, irq}, 32'h0);
        wr_reg(3'd4, 32'h0);

        // R6 resume at same index, stay halted
        mem[TBASE >> 2] = 32'h8000_0002;
        base_n = n_snd;
        wr_reg(3'd2, 32'h1);
        repeat (2) @(negedge clk);
        wait_st(32'h1);
        repeat (20) @(negedge clk);
        chk("R6 one send", 32'(n_snd - base_n), 32'd1);
        rd_reg(3'd2, rv); chk("R6 halted idx1", rv, 32'h0001_0001);
        rd_reg(3'd3, rv); chk("R6 halt event", rv, 32'h4);
        wr_reg(3'd3, 32'h7);

        // R7 graceful stop mid-frame
        mem[(TBASE >> 2) + 2] = 32'h8000_0010;
        mem[(TBASE >> 2) + 4] = 32'h8000_0012;
        base_n = n_snd;
        wr_reg(3'd2, 32'h1);
        wr_reg(3'd1, 32'h1);
        wait_st(32'h2);
        rd_reg(3'd2, rv); chk("R7 stopped idx2", rv, 32'h0002_0002);
        chk("R7 one frame", 32'(n_snd - base_n), 32'd1);
        rd_reg(3'd3, rv); chk("R7 stop event", rv, 32'h2);
        chk("R7 entry2 untouched", mem[(TBASE >> 2) + 4], 32'h8000_0012);
        wr_reg(3'd1, 32'h0);
        @(negedge clk);
        rd_reg(3'd2, rv); chk("R7 back to halt", rv, 32'h0002_0001);
        wr_reg(3'd2, 32'h1);
        repeat (2) @(negedge clk);
        wait_st(32'h1);
        chk("R7 resumed send", lg_ptr[n_snd-1], 32'h1200);
        rd_reg(3'd2, rv); chk("R7 halt idx3", rv, 32'h0003_0001);
        wr_reg(3'd3, 32'h7);

        // R9 base write resets index, single wrapping entry
        wr_reg(3'd0, 32'h87);
        rd_reg(3'd2, rv); chk("R9 idx reset", rv, 32'h1);
        rd_reg(3'd0, rv); chk("R9 base aligned", rv, 32'h80);
        mem[32] = 32'hA000_0008;
        mem[33] = 32'h0000_5A00;
        base_n = n_snd;
        wr_reg(3'd2, 32'h1);
        repeat (2) @(negedge clk);
        wait_st(32'h1);
        chk("R9 R5 single send", 32'(n_snd - base_n), 32'd1);
        chk("R9 ptr", lg_ptr[n_snd-1], 32'h5A00);
        chk("R5 R4 wrap writeback", mem[32], 32'h2000_0008);
        rd_reg(3'd2, rv); chk("R5 idx back to 0", rv, 32'h1);

        summary();
    end

endmodule